// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block generates the single synchronization line that a master timer hands to its slave timers. A small mode register picks which internal timer event drives that line: the software update-generate strobe, the counter-enable signal, the update event, a pulse for every capture/compare channel 1 event, or either of two compare reference levels. The selected source passes through one output flip-flop, so the trigger line is glitch-free and lags its source by exactly one clock.

The block also forms the counter-enable signal. Outside gated mode, counter enable is simply the software enable bit. In gated mode it is that bit ANDed with the incoming trigger. Because the trigger output is registered, any event that itself comes from the trigger input shows up on the output one clock after it happens. The reset input is asserted asynchronously and released through a synchronizer, so the block starts working a fixed number of clocks after reset is released.

Top module: `sync_trig_out`

## Requirements
- R1: After reset the mode register holds code 0, so with no write the software update-generate strobe drives the trigger output.
- R2: A mode write (write enable high for one cycle) takes effect on the cycle after the write. The trigger output computed in the write cycle still uses the old mode.
- R3: Mode code 0: trig_o in cycle t+1 equals sw_upd_gen_i in cycle t. An isolated one-cycle strobe gives a one-cycle pulse.
- R4: cnt_en_o equals cnt_en_ctl_i when gate_mode_i is low. It equals cnt_en_ctl_i AND trig_in_i when gate_mode_i is high.
- R5: Mode code 1: trig_o in cycle t+1 equals cnt_en_o in cycle t, including the case where the gating trigger input turns it on or off.
- R6: Mode code 2: trig_o in cycle t+1 equals upd_evt_i in cycle t.
- R7: Mode code 3: every cycle with cc1_evt_i high produces a high on trig_o one cycle later. Back-to-back events give back-to-back highs, with no suppression because an earlier event already occurred.
- R8: Mode code 4 forwards oc_ref1_i and mode code 5 forwards oc_ref2_i, each delayed by one cycle.
- R9: Mode codes 6 and 7 hold trig_o low whatever the source inputs do.
- R10: While reset is active, and on the cycle reset is released internally, trig_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_we_i | input | 1 | Write enable for the mode register |
| mode_wd_i | input | 3 | New mode code (0 strobe, 1 counter enable, 2 update, 3 channel 1 pulse, 4 reference 1, 5 reference 2, 6 and 7 low) |
| sw_upd_gen_i | input | 1 | Software update-generate strobe |
| cnt_en_ctl_i | input | 1 | Counter enable control bit |
| gate_mode_i | input | 1 | High when the slave controller is in gated mode |
| trig_in_i | input | 1 | Trigger input used for gating |
| upd_evt_i | input | 1 | Update event strobe |
| cc1_evt_i | input | 1 | Capture/compare channel 1 event strobe |
| oc_ref1_i | input | 1 | Compare reference level, channel 1 |
| oc_ref2_i | input | 1 | Compare reference level, channel 2 |
| cnt_en_o | output | 1 | Counter enable (combinational) |
| trig_o | output | 1 | Registered trigger output to slave timers |

## Verification
The bench uses the default parameters: a 3-bit mode field and a two-stage reset synchronizer. The 3-bit field makes all eight mode codes reachable from the bench, including the two unused codes that must hold the output low. The two-stage synchronizer sets the fixed release delay that the bench waits out before it drives events. The bench runs each mode with isolated strobes, back-to-back strobes and gated enable patterns, and it writes the mode in the same cycle that a source is active so it can check exactly when a new mode takes effect.

// File: rtl/sync_trig_out_pkg.sv
package sync_trig_out_pkg;

  localparam int MODE_W  = 3;
  localparam int NUM_SRC = 1 << MODE_W;

  localparam logic [MODE_W-1:0] MODE_SWGEN  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CNTEN  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_UPDATE = 3'd2;
  localparam logic [MODE_W-1:0] MODE_CCPULS = 3'd3;
  localparam logic [MODE_W-1:0] MODE_REF1   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_REF2   = 3'd5;

  localparam int FIRST_IDLE = 6;

endpackage

// File: rtl/sto_rst_sync.sv
module sto_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/sto_mode_reg.sv
module sto_mode_reg
  import sync_trig_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wd_i,
  output logic [MODE_W-1:0] mode_o
);

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SWGEN;
    end else if (we_i) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/sto_cen_gate.sv
module sto_cen_gate (
  input  logic ctl_i,
  input  logic gate_i,
  input  logic trig_i,
  output logic cen_o
);

  logic gate_pass;

  always_comb begin
    gate_pass = gate_i ? trig_i : 1'b1;
    cen_o     = ctl_i & gate_pass;
  end

endmodule

// File: rtl/sto_src_mux.sv
module sto_src_mux
  import sync_trig_out_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              swgen_i,
  input  logic              cen_i,
  input  logic              upd_i,
  input  logic              cc1_i,
  input  logic              ref1_i,
  input  logic              ref2_i,
  output logic              sel_o
);

  logic [NUM_SRC-1:0] src;

  assign src[MODE_SWGEN]  = swgen_i;
  assign src[MODE_CNTEN]  = cen_i;
  assign src[MODE_UPDATE] = upd_i;
  assign src[MODE_CCPULS] = cc1_i;
  assign src[MODE_REF1]   = ref1_i;
  assign src[MODE_REF2]   = ref2_i;

  for (genvar i = FIRST_IDLE; i < NUM_SRC; i++) begin : g_idle
    assign src[i] = 1'b0;
  end

  always_comb begin
    sel_o = src[mode_i];
  end

endmodule

// File: rtl/sto_out_reg.sv
module sto_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic trig_q;
  logic trig_d;

  always_comb begin
    trig_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign q_o = trig_q;

endmodule

// File: rtl/sync_trig_out.sv
module sync_trig_out
  import sync_trig_out_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wd_i,
  input  logic              sw_upd_gen_i,
  input  logic              cnt_en_ctl_i,
  input  logic              gate_mode_i,
  input  logic              trig_in_i,
  input  logic              upd_evt_i,
  input  logic              cc1_evt_i,
  input  logic              oc_ref1_i,
  input  logic              oc_ref2_i,
  output logic              cnt_en_o,
  output logic              trig_o
);

  logic              rst_n_s;
  logic [MODE_W-1:0] mode_q;
  logic              cen;
  logic              trig_sel;

  sto_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sto_mode_reg u_mode_reg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .we_i   (mode_we_i),
    .wd_i   (mode_wd_i),
    .mode_o (mode_q)
  );

  sto_cen_gate u_cen_gate (
    .ctl_i  (cnt_en_ctl_i),
    .gate_i (gate_mode_i),
    .trig_i (trig_in_i),
    .cen_o  (cen)
  );

  sto_src_mux u_src_mux (
    .mode_i  (mode_q),
    .swgen_i (sw_upd_gen_i),
    .cen_i   (cen),
    .upd_i   (upd_evt_i),
    .cc1_i   (cc1_evt_i),
    .ref1_i  (oc_ref1_i),
    .ref2_i  (oc_ref2_i),
    .sel_o   (trig_sel)
  );

  sto_out_reg u_out_reg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (trig_sel),
    .q_o   (trig_o)
  );

  assign cnt_en_o = cen;

endmodule

// File: rtl/sync_trig_out_chk.sv
module sync_trig_out_chk
  import sync_trig_out_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic [MODE_W-1:0] mode_q,
  input logic              mode_we_i,
  input logic [MODE_W-1:0] mode_wd_i,
  input logic              sw_upd_gen_i,
  input logic              cnt_en_ctl_i,
  input logic              gate_mode_i,
  input logic              trig_in_i,
  input logic              upd_evt_i,
  input logic              cc1_evt_i,
  input logic              oc_ref1_i,
  input logic              oc_ref2_i,
  input logic              cnt_en_o,
  input logic              trig_o
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (mode_q == MODE_SWGEN));

  assert_release_low_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !trig_o);

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_we_i |=> (mode_q == $past(mode_wd_i)));

  assert_swgen_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_SWGEN) |=> (trig_o == $past(sw_upd_gen_i)));

  assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    gate_mode_i |-> (cnt_en_o == (cnt_en_ctl_i & trig_in_i)));

  assert_ungated_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gate_mode_i |-> (cnt_en_o == cnt_en_ctl_i));

  assert_cnten_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_CNTEN) |=> (trig_o == $past(cnt_en_o)));

  assert_update_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_UPDATE) |=> (trig_o == $past(upd_evt_i)));

  assert_ccpulse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_CCPULS) |=> (trig_o == $past(cc1_evt_i)));

  assert_ref1_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_REF1) |=> (trig_o == $past(oc_ref1_i)));

  assert_ref2_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == MODE_REF2) |=> (trig_o == $past(oc_ref2_i)));

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q >= MODE_W'(FIRST_IDLE)) |=> !trig_o);

endmodule

bind sync_trig_out sync_trig_out_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .mode_q       (mode_q),
  .mode_we_i    (mode_we_i),
  .mode_wd_i    (mode_wd_i),
  .sw_upd_gen_i (sw_upd_gen_i),
  .cnt_en_ctl_i (cnt_en_ctl_i),
  .gate_mode_i  (gate_mode_i),
  .trig_in_i    (trig_in_i),
  .upd_evt_i    (upd_evt_i),
  .cc1_evt_i    (cc1_evt_i),
  .oc_ref1_i    (oc_ref1_i),
  .oc_ref2_i    (oc_ref2_i),
  .cnt_en_o     (cnt_en_o),
  .trig_o       (trig_o)
);

// File: tb/sync_trig_out_tb_top.sv
`timescale 1ns/1ps
module sync_trig_out_tb_top;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       mode_we_i;
  logic [2:0] mode_wd_i;
  logic       sw_upd_gen_i;
  logic       cnt_en_ctl_i;
  logic       gate_mode_i;
  logic       trig_in_i;
  logic       upd_evt_i;
  logic       cc1_evt_i;
  logic       oc_ref1_i;
  logic       oc_ref2_i;
  logic       cnt_en_o;
  logic       trig_o;

  int    n_chk;
  int    n_bad;
  bit    finished;
  logic [2:0] model_mode;
  item_t sb_q[$];

  sync_trig_out dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_we_i    (mode_we_i),
    .mode_wd_i    (mode_wd_i),
    .sw_upd_gen_i (sw_upd_gen_i),
    .cnt_en_ctl_i (cnt_en_ctl_i),
    .gate_mode_i  (gate_mode_i),
    .trig_in_i    (trig_in_i),
    .upd_evt_i    (upd_evt_i),
    .cc1_evt_i    (cc1_evt_i),
    .oc_ref1_i    (oc_ref1_i),
    .oc_ref2_i    (oc_ref2_i),
    .cnt_en_o     (cnt_en_o),
    .trig_o       (trig_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected trigger.
  task automatic drive(input bit sw, input bit ctl, input bit gate, input bit tin,
                       input bit upd, input bit cc1, input bit r1, input bit r2,
                       input bit we, input logic [2:0] wd, input string tag);
    bit cen;
    bit exp;
    item_t it;
    @(negedge clk);
    sw_upd_gen_i = sw; cnt_en_ctl_i = ctl; gate_mode_i = gate; trig_in_i = tin;
    upd_evt_i = upd; cc1_evt_i = cc1; oc_ref1_i = r1; oc_ref2_i = r2;
    mode_we_i = we; mode_wd_i = wd;
    cen = ctl & (gate ? tin : 1'b1);
    case (model_mode)
      3'd0: exp = sw;
      3'd1: exp = cen;
      3'd2: exp = upd;
      3'd3: exp = cc1;
      3'd4: exp = r1;
      3'd5: exp = r2;
      default: exp = 1'b0;
    endcase
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    if (we) model_mode = wd;
    #0.5;
    check(cnt_en_o, cen, "R4 cnt_en_o");
  endtask

  task automatic idle(input string tag);
    drive(0,0,0,0,0,0,0,0,0,3'd0,tag);
  endtask

  task automatic set_mode(input logic [2:0] m);
    drive(0,0,0,0,0,0,0,0,1,m,"R2 write");
  endtask

  // Monitor: compares the registered output right after each capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(trig_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 0; model_mode = 3'd0;
    rst_n = 1'b1;
    mode_we_i = 0; mode_wd_i = 3'd7;
    sw_upd_gen_i = 1; cnt_en_ctl_i = 1; gate_mode_i = 0; trig_in_i = 1;
    upd_evt_i = 1; cc1_evt_i = 1; oc_ref1_i = 1; oc_ref2_i = 1;
    #1 rst_n = 1'b0;
    // R10: output stays low during reset even with every source high
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(trig_o, 1'b0, "R10 in reset");
    end
    sw_upd_gen_i = 0; cnt_en_ctl_i = 0; trig_in_i = 0;
    upd_evt_i = 0; cc1_evt_i = 0; oc_ref1_i = 0; oc_ref2_i = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(trig_o, 1'b0, "R10 after release");

    // R1 / R3: default mode forwards the software strobe, one cycle wide
    idle("R1 idle");
    drive(1,0,0,0,0,0,0,0,0,3'd0,"R1 strobe");
    idle("R3 after strobe");
    drive(0,1,0,1,1,1,1,1,0,3'd0,"R3 others ignored");
    drive(1,0,0,0,0,0,0,0,0,3'd0,"R3 strobe");
    drive(1,0,0,0,0,0,0,0,0,3'd0,"R3 strobe again");
    idle("R3 low");

    // R2: write in a cycle where old source is high and new source low
    drive(1,0,0,0,0,0,0,0,1,3'd2,"R2 old mode in write cycle");
    drive(1,0,0,0,0,0,0,0,0,3'd0,"R2 new mode ignores strobe");

    // R6: update event
    drive(0,0,0,0,1,0,0,0,0,3'd0,"R6 update");
    idle("R6 low");
    drive(0,0,0,0,1,0,0,0,0,3'd0,"R6 update 2");

    // R5 / R4: counter enable with and without gating
    set_mode(3'd1);
    drive(0,1,0,0,0,0,0,0,0,3'd0,"R5 ungated on");
    drive(0,1,1,0,0,0,0,0,0,3'd0,"R5 gated blocked");
    drive(0,1,1,1,0,0,0,0,0,3'd0,"R5 gated pass");
    drive(0,0,1,1,0,0,0,0,0,3'd0,"R5 ctl off");
    drive(0,0,0,1,0,0,0,0,0,3'd0,"R5 ctl off ungated");
    drive(0,1,1,1,0,0,0,0,0,3'd0,"R5 trigger on");
    drive(0,1,1,0,0,0,0,0,0,3'd0,"R5 trigger off");

    // R7: capture/compare pulses, back to back
    set_mode(3'd3);
    drive(0,0,0,0,0,1,0,0,0,3'd0,"R7 event");
    drive(0,0,0,0,0,1,0,0,0,3'd0,"R7 back-to-back");
    drive(0,0,0,0,0,1,0,0,0,3'd0,"R7 third");
    idle("R7 low");
    drive(1,0,0,0,1,1,0,0,0,3'd0,"R7 single");
    idle("R7 end");

    // R8: reference levels
    set_mode(3'd4);
    drive(0,0,0,0,0,0,1,0,0,3'd0,"R8 ref1 high");
    drive(0,0,0,0,0,0,1,1,0,3'd0,"R8 ref1 held");
    drive(0,0,0,0,0,0,0,1,0,3'd0,"R8 ref1 low");
    set_mode(3'd5);
    drive(0,0,0,0,0,0,0,1,0,3'd0,"R8 ref2 high");
    drive(0,0,0,0,0,0,1,0,0,3'd0,"R8 ref2 low");

    // R9: idle codes with every source high
    set_mode(3'd6);
    drive(1,1,0,1,1,1,1,1,0,3'd0,"R9 code 6");
    set_mode(3'd7);
    drive(1,1,0,1,1,1,1,1,0,3'd0,"R9 code 7");
    drive(1,1,1,1,1,1,1,1,0,3'd0,"R9 code 7 gated");

    // R2: back to mode 0
    set_mode(3'd0);
    drive(1,0,0,0,0,0,0,0,0,3'd0,"R2 back to strobe");
    idle("R2 end");

    for (int i = 0; i < 3; i++) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule